// File: doc/BRIEF.md
# Receive Character Buffer with Sticky Error Flags

This block sits behind a serial receiver's deserializer. Each time the deserializer finishes a character it raises a one-cycle completion strobe with the data byte, the parity bit it sampled and the stop bit it sampled. The block latches the byte into a holding buffer, raises a data-available flag, and checks the character for three faults: a parity mismatch (only when parity checking is on, with an odd/even sense select), a missing stop bit, and an overrun, which is a new character landing while the previous one was never read.

The three fault flags are sticky. Reading the byte, or receiving later clean characters, leaves them set. Only two things clear them: a one-cycle clear-errors pulse from control logic, or the synchronous active-low reset. When a clear pulse and a new fault meet in the same clock, the fault wins. Bit sampling and baud timing are done elsewhere.

Top module: `rx_err_status`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is rx_data = 0, data_avail = 0, and all three error flags = 0.
- R2: A clock with char_done high loads char_data into rx_data and sets data_avail, both visible after that edge.
- R3: A clock with host_read high and char_done low clears data_avail. rx_data keeps its value whenever char_done is low.
- R4: With parity_en = 1, a completed character sets err_parity when the parity bit is wrong. With parity_odd = 0 (even sense), the correct bit equals the XOR of the 8 data bits. With parity_odd = 1 (odd sense), the correct bit is the inverse of that XOR.
- R5: With parity_en = 0, no character sets err_parity, whatever its parity bit is.
- R6: A completed character sets err_overrun when data_avail was already 1 and host_read is low in that same clock. If host_read is high in that clock, the old byte counts as read and no overrun is flagged.
- R7: A completed character whose stop bit (char_stop) is 0 sets err_framing.
- R8: Once set, an error flag stays set through later clean characters and host reads until clear_errors or reset.
- R9: A clock with clear_errors high and no new fault of that kind clears the flag after the edge.
- R10: When clear_errors and a new fault of a given kind occur in the same clock, that flag is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a character has been completed by the deserializer |
| char_data | input | 8 | Received data byte, valid with char_done |
| char_parity | input | 1 | Received parity bit, valid with char_done |
| char_stop | input | 1 | Received stop bit, valid with char_done |
| parity_en | input | 1 | Enables parity checking |
| parity_odd | input | 1 | 1 = odd parity sense, 0 = even |
| host_read | input | 1 | Processor read of the buffered byte |
| clear_errors | input | 1 | One-cycle pulse clearing all three error flags |
| rx_data | output | 8 | Buffered received byte |
| data_avail | output | 1 | A byte is waiting to be read |
| err_parity | output | 1 | Sticky parity error flag |
| err_overrun | output | 1 | Sticky overrun flag |
| err_framing | output | 1 | Sticky framing error flag |

## Verification
The embedded properties check these local, cycle-to-cycle rules on every clock:
- each fault event sets its flag on the next cycle;
- a set flag holds unless a clear pulse arrives;
- a clear pulse with no competing fault empties the flag;
- the buffer holds its byte and its available flag by the completion and read rules;
- reset zeroes all state.

Some behaviour only shows over a sequence of characters, so it comes from the bench's scenarios. These cover:
- overrun from two completions with no read between them, and the read-in-the-same-clock exemption;
- both parity senses, with correct and wrong bits;
- parity masking while checking is off;
- flags surviving later clean traffic.

// File: rtl/rx_err_pkg.sv
// Shared definitions for the receive status block: data width and the
// bit positions of the three error flags inside the flag vector.
package rx_err_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NUM_ERR = 3;

    // Index of each fault inside the error vectors
    localparam int unsigned ERR_PAR = 0;
    localparam int unsigned ERR_OVR = 1;
    localparam int unsigned ERR_FRM = 2;
endpackage

// File: rtl/rx_err_detect.sv
// Fault detector: decides, combinationally, which faults the character
// presented in this cycle carries.
// Assumes char_done is a single-cycle strobe and buf_full is the registered
// data-available flag of the holding buffer.
module rx_err_detect
    import rx_err_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic               char_done,
    input  logic [W-1:0]       char_data,
    input  logic               char_parity,
    input  logic               char_stop,
    input  logic               parity_en,
    input  logic               parity_odd,
    input  logic               buf_full,
    input  logic               host_read,
    output logic [NUM_ERR-1:0] evt
);
    logic data_xor;
    logic want_bit;

    // Expected parity bit for the selected sense
    always_comb begin
        data_xor = ^char_data;
        want_bit = parity_odd ? ~data_xor : data_xor;
    end

    // Raise one event line per fault found on this character
    always_comb begin
        evt          = '0;
        evt[ERR_PAR] = char_done && parity_en && (char_parity != want_bit);
        evt[ERR_OVR] = char_done && buf_full && !host_read;
        evt[ERR_FRM] = char_done && !char_stop;
    end

    // R5: no parity event can come out while checking is off
    always_comb begin
        if (!parity_en) begin
            a_no_par_evt_r5: assert (evt[ERR_PAR] == 1'b0);
        end
    end
endmodule

// File: rtl/rx_err_sticky.sv
// One sticky error flag. It is set by a fault event and cleared only by the
// clear pulse or reset. The event wins over a clear in the same cycle.
// Assumes set_evt and clr are synchronous to clk.
module rx_err_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    // Flag register: clear first, then OR in the new event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= (clr ? 1'b0 : flag) | set_evt;
        end
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> !flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set_evt |=> !flag);

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
endmodule

// File: rtl/rx_char_hold.sv
// Receive holding buffer: captures each completed byte and tracks whether
// the processor has yet to read it.
// Assumes host_read is a single-cycle strobe per read.
module rx_char_hold
    import rx_err_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         char_done,
    input  logic [W-1:0] char_data,
    input  logic         host_read,
    output logic [W-1:0] rx_data,
    output logic         data_avail
);
    // Byte register: load on completion, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (char_done) begin
            rx_data <= char_data;
        end
    end

    // Availability flag: completion sets it, a read clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_avail <= 1'b0;
        end else if (char_done) begin
            data_avail <= 1'b1;
        end else if (host_read) begin
            data_avail <= 1'b0;
        end
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> (!data_avail && rx_data == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> (data_avail && rx_data == $past(char_data)));

    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_read && !char_done |=> !data_avail);

    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !char_done |=> $stable(rx_data));
endmodule

// File: rtl/rx_err_status.sv
// Top: receive buffer plus three sticky error flags (parity, overrun and
// framing). The flags ignore reads and clean characters; they clear only on
// clear_errors or reset.
// Assumes a deserializer upstream that presents a whole character with a
// one-cycle char_done strobe.
module rx_err_status
    import rx_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_parity,
    input  logic              char_stop,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              host_read,
    input  logic              clear_errors,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_avail,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_framing
);
    logic [NUM_ERR-1:0] fault_evt;
    logic [NUM_ERR-1:0] fault_flag;

    rx_char_hold #(.W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_done  (char_done),
        .char_data  (char_data),
        .host_read  (host_read),
        .rx_data    (rx_data),
        .data_avail (data_avail)
    );

    rx_err_detect #(.W(DATA_W)) u_detect (
        .char_done   (char_done),
        .char_data   (char_data),
        .char_parity (char_parity),
        .char_stop   (char_stop),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .buf_full    (data_avail),
        .host_read   (host_read),
        .evt         (fault_evt)
    );

    // One sticky flag per fault kind
    for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
        rx_err_sticky u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (fault_evt[g]),
            .clr     (clear_errors),
            .flag    (fault_flag[g])
        );
    end

    // Map the flag vector onto the named outputs
    always_comb begin
        err_parity  = fault_flag[ERR_PAR];
        err_overrun = fault_flag[ERR_OVR];
        err_framing = fault_flag[ERR_FRM];
    end

    p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && parity_en && (char_parity ^ (^char_data) ^ parity_odd)
        |=> err_parity);

    p_no_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_en && !err_parity |=> !err_parity);

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && data_avail && !host_read |=> err_overrun);

    p_framing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && !char_stop |=> err_framing);
endmodule

// File: tb/rx_err_status_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one clock of stimulus, updates a
// reference model and queues the expected outputs; the monitor pops and
// compares them at the falling edge after the design has updated.
module rx_err_status_bench;
    localparam int unsigned W = 8;
    localparam int unsigned WATCHDOG_CYCLES = 200000;

    typedef struct packed {
        logic [W-1:0] data;
        logic         avail;
        logic         perr;
        logic         oerr;
        logic         ferr;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         char_done, char_parity, char_stop;
    logic [W-1:0] char_data;
    logic         parity_en, parity_odd, host_read, clear_errors;
    logic [W-1:0] rx_data;
    logic         data_avail, err_parity, err_overrun, err_framing;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  model;
    int    checks = 0;
    int    fails  = 0;
    bit    done_flag = 1'b0;

    always #5 clk = ~clk;

    rx_err_status u_rx_err_status (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
        .char_parity(char_parity), .char_stop(char_stop), .parity_en(parity_en),
        .parity_odd(parity_odd), .host_read(host_read), .clear_errors(clear_errors),
        .rx_data(rx_data), .data_avail(data_avail), .err_parity(err_parity),
        .err_overrun(err_overrun), .err_framing(err_framing)
    );

    // Count the ones in a byte, bit by bit
    function automatic logic ones_odd(input logic [W-1:0] d);
        logic acc = 1'b0;
        for (int i = 0; i < W; i++) acc = acc ^ d[i];
        return acc;
    endfunction

    // The correct parity bit for a byte under the chosen sense
    function automatic logic good_parity(input logic [W-1:0] d, input logic odd);
        return odd ? !ones_odd(d) : ones_odd(d);
    endfunction

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; char_done = 0; char_data = '0; char_parity = 0; char_stop = 1;
        parity_en = 0; parity_odd = 0; host_read = 0; clear_errors = 0;
        model = '0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle of stimulus plus the model's next state
    task automatic step(input logic done, input logic [W-1:0] d, input logic par,
                        input logic stop, input logic pen, input logic podd,
                        input logic rd, input logic clr, input string tag);
        logic pe, oe, fe;
        @(negedge clk);
        char_done = done; char_data = d; char_parity = par; char_stop = stop;
        parity_en = pen; parity_odd = podd; host_read = rd; clear_errors = clr;
        pe = done && pen && (par != good_parity(d, podd));
        oe = done && model.avail && !rd;
        fe = done && !stop;
        model.perr = (clr ? 1'b0 : model.perr) | pe;
        model.oerr = (clr ? 1'b0 : model.oerr) | oe;
        model.ferr = (clr ? 1'b0 : model.ferr) | fe;
        if (done) begin
            model.data  = d;
            model.avail = 1'b1;
        end else if (rd) begin
            model.avail = 1'b0;
        end
        @(posedge clk);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 8'h00, 0, 1, parity_en, parity_odd, 0, 0, tag);
    endtask

    // Monitor: compare design outputs against the queued expectation
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {rx_data, data_avail, err_parity, err_overrun, err_framing};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: got data=%h av=%b pe=%b oe=%b fe=%b, expected data=%h av=%b pe=%b oe=%b fe=%b",
                         t, a.data, a.avail, a.perr, a.oerr, a.ferr,
                         e.data, e.avail, e.perr, e.oerr, e.ferr);
            end
        end
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        // R2: capture a byte with correct even parity
        step(1, 8'hA5, good_parity(8'hA5, 0), 1, 1, 0, 0, 0, "R2 capture");
        idle("R2 hold after capture");
        // R3: read clears availability, data held
        step(0, 8'h00, 0, 1, 1, 0, 1, 0, "R3 read clears avail");
        idle("R3 data held");
        // R4: wrong even parity bit
        step(1, 8'h3C, !good_parity(8'h3C, 0), 1, 1, 0, 0, 0, "R4 even parity wrong");
        // R8: read and clean character keep flag
        step(0, 8'h00, 0, 1, 1, 0, 1, 0, "R8 read keeps parity flag");
        step(1, 8'h11, good_parity(8'h11, 0), 1, 1, 0, 0, 0, "R8 good char keeps flag");
        step(0, 8'h00, 0, 1, 1, 0, 1, 0, "R8 read");
        // R9: clear with no fault
        step(0, 8'h00, 0, 1, 1, 0, 0, 1, "R9 clear");
        // R4: odd sense correct then wrong
        step(1, 8'h07, good_parity(8'h07, 1), 1, 1, 1, 0, 0, "R4 odd parity correct");
        step(0, 8'h00, 0, 1, 1, 1, 1, 0, "R4 read");
        step(1, 8'hF0, !good_parity(8'hF0, 1), 1, 1, 1, 0, 0, "R4 odd parity wrong");
        step(0, 8'h00, 0, 1, 0, 0, 1, 1, "R9 clear after parity");
        // R5: parity disabled, wrong bit ignored
        step(1, 8'h81, !good_parity(8'h81, 0), 1, 0, 0, 0, 0, "R5 parity disabled");
        step(1, 8'h82, good_parity(8'h82, 0), 1, 0, 0, 0, 0, "R6 overrun two chars");
        step(0, 8'h00, 0, 1, 0, 0, 1, 1, "R9 clear overrun");
        // R6: completion with read in the same clock
        step(1, 8'h55, 0, 1, 0, 0, 0, 0, "R6 fill buffer");
        step(1, 8'h66, 0, 1, 0, 0, 1, 0, "R6 read same clock no overrun");
        step(0, 8'h00, 0, 1, 0, 0, 1, 0, "R6 read");
        // R7: framing error
        step(1, 8'h99, 0, 0, 0, 0, 0, 0, "R7 framing");
        step(0, 8'h00, 0, 1, 0, 0, 1, 0, "R8 framing sticky");
        // R10: clear meets new framing fault
        step(1, 8'h44, 0, 0, 0, 0, 0, 1, "R10 event wins over clear");
        // R10 plus overrun and parity together with clear
        step(1, 8'h0F, !good_parity(8'h0F, 0), 0, 1, 0, 0, 1, "R10 all faults with clear");
        step(0, 8'h00, 0, 1, 0, 0, 0, 1, "R9 clear all");
        do_reset("R1 reset after traffic");
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule